// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits. Every bit pair `op_a[i] & op_b[j]` is formed at the same moment, so the block produces one row per multiplier bit. Each row is the multiplicand gated by one multiplier bit and moved left by that bit's index. The rows are then folded together by a linear chain of 3:2 compressors. The chain keeps a running sum vector and a running carry vector and never lets a carry travel along a word. One carry-propagate adder at the end of the chain combines the two vectors into the product.

The parameter `OUT_REG` sets where the result appears. At 0 the product is combinational and valid in the same cycle as the operands. At 1 the product is captured in an output register for timing closure and appears one clock later. The multiplier is sized by `WIDTH`, which must be 2 or more.

Top module: `csa_array_mult`

## Requirements
- R1: For every pair of unsigned operands, `product` equals `op_a * op_b` exactly, in `2*WIDTH` bits.
- R2: Partial-product row j equals `op_a` when `op_b[j]` is 1 and zero otherwise, shifted left by j bits. A multiplier with a single bit j set therefore yields `op_a << j`.
- R3: Each 3:2 stage turns inputs x, y and z into two outputs. The sum is the bitwise XOR of the three inputs. The carry is their bitwise majority moved up one bit position, with bit 0 cleared. The sum output plus the carry output equals x + y + z. For x=3, y=2 and z=3 in 4 bits, the sum is 2, the carry is 6, and their total is 8.
- R4: No carry leaves the top of the `2*WIDTH`-bit vectors, either in any 3:2 stage or in the final adder. The largest operands give `(2^WIDTH-1)^2`.
- R5: With `OUT_REG`=1, `product` reads 0 while `rst_n` is low. Otherwise it shows the product of the operands present at the previous rising edge of `clk`.
- R6: With `OUT_REG`=0, `product` follows the operands within the same cycle, without waiting for a clock edge.
- R7: A zero operand on either side gives a zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| product | output | 2*WIDTH | Full unsigned product |

## Verification
Some properties are checked on every evaluation by the assertions. The rows must add up to the arithmetic product. Each compressor must preserve the total of its three inputs and must lose nothing off the top. The final adder must not overflow. The port-level product must match the reference one cycle late or in the same cycle, depending on `OUT_REG`. Some behaviour only the bench scenarios can show. These are the all-operand sweep of the 4-bit registered build, the reset value, random wide operands on the 16-bit combinational build, the one-hot multiplier patterns, the extreme operands and the worked 3+2+3 compressor example.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // Width of the full product for an n-bit operand pair.
  function automatic int unsigned prod_width(input int unsigned n);
    return 2 * n;
  endfunction

  // Number of 3:2 stages in a linear array folding n rows into two.
  function automatic int unsigned stage_count(input int unsigned n);
    return (n > 2) ? (n - 2) : 0;
  endfunction

endpackage

// File: rtl/csa_pp_gen.sv
module csa_pp_gen #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = csa_pkg::prod_width(WIDTH)
) (
  input  logic [WIDTH-1:0]         mcand,
  input  logic [WIDTH-1:0]         mplier,
  output logic [WIDTH-1:0][PW-1:0] rows
);

  // One row: multiplicand gated by one multiplier bit, placed at its weight.
  function automatic logic [PW-1:0] gated_row(input logic [WIDTH-1:0] m,
                                              input logic gate,
                                              input int unsigned pos);
    logic [PW-1:0] wide;
    wide = {{WIDTH{1'b0}}, m};
    return gate ? (wide << pos) : '0;
  endfunction

  for (genvar j = 0; j < WIDTH; j++) begin : g_row
    assign rows[j] = gated_row(mcand, mplier[j], j);
  end

  // Total of all rows, brought out for the R2 check.
  logic [PW-1:0] rows_total;
  always_comb begin
    rows_total = '0;
    for (int j = 0; j < WIDTH; j++) rows_total = rows_total + rows[j];
  end

  always_comb begin
    if (!$isunknown({mcand, mplier}))
      assert_rows_total_R2: assert (rows_total ==
        ({{WIDTH{1'b0}}, mcand} * {{WIDTH{1'b0}}, mplier}))
        else $error("rows do not add up to the product");
  end

endmodule

// File: rtl/csa_stage.sv
module csa_stage #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);

  function automatic logic [W-1:0] majority(input logic [W-1:0] p,
                                            input logic [W-1:0] q,
                                            input logic [W-1:0] r);
    return (p & q) | (p & r) | (q & r);
  endfunction

  logic [W-1:0] maj;
  logic         carry_spill;

  assign maj         = majority(x, y, z);
  assign sum_o       = x ^ y ^ z;
  assign carry_o     = {maj[W-2:0], 1'b0};
  assign carry_spill = maj[W-1];

  // Totals in a wider word so the conservation check cannot wrap.
  logic [W+1:0] in_total;
  logic [W+1:0] out_total;
  assign in_total  = {2'b00, x} + {2'b00, y} + {2'b00, z};
  assign out_total = {2'b00, sum_o} + {2'b00, carry_o};

  always_comb begin
    if (!$isunknown({x, y, z})) begin
      assert_stage_conserves_R3: assert (carry_spill || (in_total == out_total))
        else $error("3:2 stage changed the total");
      assert_no_stage_spill_R4: assert (!carry_spill)
        else $error("carry lost off the top of a 3:2 stage");
    end
  end

endmodule

// File: rtl/csa_cpa.sv
module csa_cpa #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] c_in,
  output logic [W-1:0] result
);

  function automatic logic [W:0] propagate_add(input logic [W-1:0] p,
                                               input logic [W-1:0] q);
    return {1'b0, p} + {1'b0, q};
  endfunction

  logic [W:0] full;
  logic       final_spill;

  assign full        = propagate_add(s_in, c_in);
  assign result      = full[W-1:0];
  assign final_spill = full[W];

  always_comb begin
    if (!$isunknown({s_in, c_in}))
      assert_no_final_spill_R4: assert (!final_spill)
        else $error("final adder overflowed");
  end

endmodule

// File: rtl/csa_array_mult.sv
module csa_array_mult #(
  parameter int unsigned WIDTH   = 8,
  parameter bit          OUT_REG = 1'b0,
  localparam int unsigned PW     = csa_pkg::prod_width(WIDTH),
  localparam int unsigned NSTAGE = csa_pkg::stage_count(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic [PW-1:0]    product
);

  logic [WIDTH-1:0][PW-1:0] rows;

  csa_pp_gen #(.WIDTH(WIDTH)) u_pp (
    .mcand (op_a),
    .mplier(op_b),
    .rows  (rows)
  );

  // Running sum / carry pair; index k holds the pair after k stages.
  logic [NSTAGE:0][PW-1:0] acc_s;
  logic [NSTAGE:0][PW-1:0] acc_c;

  assign acc_s[0] = rows[0];
  assign acc_c[0] = rows[1];

  for (genvar k = 1; k <= NSTAGE; k++) begin : g_stage
    csa_stage #(.W(PW)) u_stage (
      .x      (acc_s[k-1]),
      .y      (acc_c[k-1]),
      .z      (rows[k+1]),
      .sum_o  (acc_s[k]),
      .carry_o(acc_c[k])
    );
  end

  logic [PW-1:0] cpa_out;

  csa_cpa #(.W(PW)) u_cpa (
    .s_in  (acc_s[NSTAGE]),
    .c_in  (acc_c[NSTAGE]),
    .result(cpa_out)
  );

  // Arithmetic reference, used only by the port-level assertions.
  logic [PW-1:0] ref_now;
  assign ref_now = PW'(op_a) * PW'(op_b);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) product <= '0;
      else        product <= cpa_out;
    end

    always_comb begin
      if (!rst_n)
        assert_reset_zero_R5: assert (product == '0)
          else $error("registered product not cleared in reset");
    end

    assert_registered_product_R5: assert property (
      @(posedge clk) disable iff (!rst_n)
      !$isunknown({op_a, op_b}) |=> (product == $past(ref_now)))
      else $error("registered product mismatch");
  end else begin : g_comb
    assign product = cpa_out;

    assert_same_cycle_product_R6: assert property (
      @(posedge clk) disable iff (!rst_n)
      !$isunknown({op_a, op_b}) |-> (product == ref_now))
      else $error("combinational product mismatch");
  end

endmodule

// File: tb/test_csa_array_mult.sv
module test_csa_array_mult;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // 4-bit registered build, swept over every operand pair.
  logic [3:0] a4, b4;
  logic [7:0] p4;
  csa_array_mult #(.WIDTH(4), .OUT_REG(1'b1)) i_csa_array_mult (
    .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4), .product(p4));

  // 16-bit combinational build, random operands.
  logic [15:0] a16, b16;
  logic [31:0] p16;
  csa_array_mult #(.WIDTH(16), .OUT_REG(1'b0)) i_csa_array_mult_w16 (
    .clk(clk), .rst_n(rst_n), .op_a(a16), .op_b(b16), .product(p16));

  // A lone 3:2 stage for the worked compressor example.
  logic [3:0] sx, sy, sz, ss, sc;
  csa_stage #(.W(4)) i_stage (
    .x(sx), .y(sy), .z(sz), .sum_o(ss), .carry_o(sc));

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // Registered build: drive at a falling edge, read at the next falling edge.
  task automatic mul4(input int a, input int b, input string req);
    @(negedge clk);
    a4 = 4'(a); b4 = 4'(b);
    @(negedge clk);
    check(req, longint'(p4), longint'(a * b));
  endtask

  // Combinational build: read shortly after driving.
  task automatic mul16(input longint a, input longint b, input string req);
    a16 = 16'(a); b16 = 16'(b);
    #1;
    check(req, longint'(p16), a * b);
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    a4 = '0; b4 = '0; a16 = '0; b16 = '0;
    sx = '0; sy = '0; sz = '0;

    // R5: registered output holds zero during reset, whatever the operands.
    a4 = 4'd7; b4 = 4'd9;
    repeat (3) @(negedge clk);
    check("R5 reset value", longint'(p4), 0);
    rst_n = 1'b1;

    // R3: worked compressor example 3 + 2 + 3.
    sx = 4'd3; sy = 4'd2; sz = 4'd3;
    #1;
    check("R3 sum vector", longint'(ss), 2);
    check("R3 carry vector", longint'(sc), 6);
    check("R3 total", longint'(ss) + longint'(sc), 8);

    // R1 / R5: every operand pair on the 4-bit registered build.
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        mul4(a, b, "R1 R5 exhaustive 4-bit");

    // R2: one-hot multiplier picks a shifted multiplicand.
    for (int j = 0; j < 4; j++) mul4(11, 1 << j, "R2 one-hot 4-bit");
    for (int j = 0; j < 16; j++) mul16(16'hB5C3, longint'(1) << j, "R2 one-hot 16-bit");

    // R4: largest operands.
    mul4(15, 15, "R4 max 4-bit");
    mul16(65535, 65535, "R4 max 16-bit");

    // R7: zero on either side.
    mul16(0, 51234, "R7 zero multiplicand");
    mul16(40961, 0, "R7 zero multiplier");
    mul4(0, 13, "R7 zero 4-bit");

    // R6: combinational result settles within the cycle, no edge needed.
    @(posedge clk);
    #0.5;
    a16 = 16'd1234; b16 = 16'd4321;
    #0.5;
    check("R6 same cycle", longint'(p16), 64'd1234 * 64'd4321);

    // R1: random wide operands, one pair per cycle.
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      mul16(longint'($urandom() & 32'hFFFF), longint'($urandom() & 32'hFFFF),
            "R1 random 16-bit");
    end

    // R5: holding operands across edges keeps the registered product steady.
    mul4(9, 14, "R5 hold first");
    @(negedge clk);
    check("R5 hold steady", longint'(p4), 126);

    report();
  end

endmodule